// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

The engine walks a chain of transmit descriptors held in system memory and turns the buffers they point at into outgoing frames on a byte stream. Software first loads the list head address. It then writes the transmit control word with the DMA-enable bit set. The engine reads each descriptor and the bytes of its buffer through a word-wide request/response memory port. It concatenates the buffers of consecutive descriptors into one frame store. When it reaches a descriptor flagged as the end of a frame, it sends the whole frame on a valid/ready/last byte stream.

After a descriptor's buffer has been taken, the descriptor is handed back to software by writing its status word with the ownership bit cleared. The walk stops at the first descriptor the engine does not own. It also stops when a frame would overflow the frame store; in that case the offending descriptor is flagged with a length error. A walk that sent at least one frame raises a sticky transmit-complete flag and clears the DMA-start bit of the control word.

Top module: `tx_gather_engine`

## Requirements
- R1: While idle, a pulse on `head_wr` loads `head_addr` into both the list head and the current-descriptor pointer; `cur_desc` shows that value on the next cycle.
- R2: While idle, a pulse on `ctl_wr` stores `ctl_wdata` into `ctl_q`. Bit 30 set starts a walk at the list head; bit 30 clear starts nothing. A descriptor at byte address A holds four words: status at A, status2 at A+4, buffer address at A+8 and next-descriptor address at A+12. A memory request is held, with the same address, until it is acknowledged.
- R3: Only a descriptor whose status bit 31 is set is processed. The walk ends at the first descriptor whose status bit 31 is clear, and that descriptor is not written.
- R4: The buffer byte count is status2 bits 10:0. The buffer is read as little-endian 32-bit words from a word-aligned address: byte k of the buffer is bits 8*(k%4)+7:8*(k%4) of the word at buffer+4*(k/4). Bytes past the count are dropped.
- R5: The buffers of consecutive descriptors are joined in walk order. A frame is sent only after the descriptor whose status2 bit 30 is set, with `out_last` on its final byte. Bytes gathered after the last such descriptor of a walk are never sent.
- R6: Each consumed descriptor's status word is written back with bit 31 cleared and all other bits unchanged.
- R7: If the joined frame would exceed MAX_FRAME (2048) bytes, that descriptor's status is written back with bit 14 set and bit 31 kept. The walk then ends and the partial frame is dropped.
- R8: At the end of a walk that sent at least one frame, `irq_flag` is set and `ctl_q` bit 31 is cleared; otherwise both are left as they were.
- R9: `busy` is high from the kick until the walk ends. While busy, control and head writes are ignored. While idle, no memory request and no stream beat is made.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady.
- R11: `irq_flag` stays set until a pulse on `irq_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_wr | input | 1 | Load list head and current pointer |
| head_addr | input | AW | List head address |
| ctl_wr | input | 1 | Write transmit control word |
| ctl_wdata | input | 32 | Control word value (bit 30 DMA enable, bit 31 DMA start) |
| ctl_q | output | 32 | Stored control word |
| irq_clr | input | 1 | Clear transmit-complete flag |
| irq_flag | output | 1 | Transmit-complete flag |
| busy | output | 1 | Walk in progress |
| cur_desc | output | AW | Current descriptor address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of frame |

## Verification
The bench targets the cases where a frame spans several descriptors. It covers a zero-count descriptor inside a frame, and a chain that ends without a final descriptor. A design that sent on every descriptor, or that kept stale bytes, would show extra or misplaced `out_last` beats. Counts that are not a multiple of four show whether spare byte lanes are dropped. An overflowing chain checks that bit 14 lands on the right descriptor with ownership kept, and that no bytes leak out. A walk that starts on an unowned head must leave `irq_flag` and the start bit alone. A kick during a stalled stream must not restart or corrupt the walk.

// File: rtl/tx_gather_engine.sv
module tx_gather_engine #(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_wr,
  input  logic [AW-1:0] head_addr,
  input  logic          ctl_wr,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_q,
  input  logic          irq_clr,
  output logic          irq_flag,
  output logic          busy,
  output logic [AW-1:0] cur_desc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last
);
  localparam int IW  = $clog2(MAX_FRAME);
  localparam int LW  = IW + 1;
  localparam int WIW = IW - 1;

  typedef enum logic [2:0] {S_IDLE, S_DESC, S_BUF, S_WB, S_EMIT, S_END} st_t;
  st_t st;

  logic [1:0]     widx;
  logic [31:0]    stat_q, stat2_q;
  logic [AW-1:0]  baddr_q, next_q, head_q;
  logic [WIW-1:0] wi_q;
  logic [LW-1:0]  flen_q, ptr_q;
  logic           sent_q, err_q;
  logic [7:0]     fbuf [MAX_FRAME];

  wire [LW-1:0] cnt    = LW'(stat2_q[10:0]);
  wire [LW-1:0] boff   = {wi_q, 2'b00};
  wire [LW:0]   total  = {1'b0, flen_q} + (LW+1)'(mem_rdata[10:0]);
  wire          buf_done = (boff + LW'(4)) >= cnt;
  wire          beat   = out_valid && out_ready;

  assign busy      = st != S_IDLE;
  assign mem_req   = st == S_DESC || st == S_BUF || st == S_WB;
  assign mem_we    = st == S_WB;
  assign mem_addr  = st == S_BUF ? baddr_q + AW'({wi_q, 2'b00}) :
                     st == S_DESC ? cur_desc + AW'({widx, 2'b00}) : cur_desc;
  assign mem_wdata = err_q ? (stat_q | 32'h0000_4000) : (stat_q & 32'h7fff_ffff);
  assign out_valid = st == S_EMIT;
  assign out_data  = fbuf[ptr_q[IW-1:0]];
  assign out_last  = ptr_q == flen_q - LW'(1);

  always_ff @(posedge clk) begin
    if (st == S_BUF && mem_ack)
      for (int l = 0; l < 4; l++)
        if (boff + LW'(l) < cnt)
          fbuf[IW'(flen_q + boff + LW'(l))] <= mem_rdata[8*l +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; widx <= '0; stat_q <= '0; stat2_q <= '0;
      baddr_q <= '0; next_q <= '0; head_q <= '0; cur_desc <= '0;
      wi_q <= '0; flen_q <= '0; ptr_q <= '0; sent_q <= 1'b0; err_q <= 1'b0;
      ctl_q <= '0; irq_flag <= 1'b0;
    end else begin
      if (irq_clr) irq_flag <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (head_wr) begin
            head_q <= head_addr; cur_desc <= head_addr;
          end
          if (ctl_wr) begin
            ctl_q <= ctl_wdata;
            if (ctl_wdata[30]) begin
              cur_desc <= head_q; flen_q <= '0; sent_q <= 1'b0;
              err_q <= 1'b0; widx <= '0; st <= S_DESC;
            end
          end
        end
        S_DESC: if (mem_ack) begin
          widx <= widx + 2'd1;
          unique case (widx)
            2'd0: begin
              stat_q <= mem_rdata;
              if (!mem_rdata[31]) st <= S_END;
            end
            2'd1: begin
              stat2_q <= mem_rdata;
              if (total > (LW+1)'(MAX_FRAME)) begin
                err_q <= 1'b1; st <= S_WB;
              end
            end
            2'd2: baddr_q <= mem_rdata[AW-1:0];
            default: begin
              next_q <= mem_rdata[AW-1:0]; wi_q <= '0;
              st <= (cnt == '0) ? S_WB : S_BUF;
            end
          endcase
        end
        S_BUF: if (mem_ack) begin
          wi_q <= wi_q + WIW'(1);
          if (buf_done) begin
            flen_q <= flen_q + cnt; st <= S_WB;
          end
        end
        S_WB: if (mem_ack) begin
          widx <= '0;
          if (err_q) st <= S_END;
          else if (stat2_q[30] && flen_q != '0) begin
            ptr_q <= '0; st <= S_EMIT;
          end else begin
            if (stat2_q[30]) sent_q <= 1'b1;
            cur_desc <= next_q; st <= S_DESC;
          end
        end
        S_EMIT: if (beat) begin
          ptr_q <= ptr_q + LW'(1);
          if (out_last) begin
            flen_q <= '0; sent_q <= 1'b1; cur_desc <= next_q; st <= S_DESC;
          end
        end
        default: begin
          if (sent_q) begin
            irq_flag <= 1'b1; ctl_q[31] <= 1'b0;
          end
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module tx_gather_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          head_wr,
  input logic          busy,
  input logic          irq_flag,
  input logic [AW-1:0] cur_desc,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last
);
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !out_valid); // R9
  AST_WB_OWNERSHIP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31] || mem_wdata[14]); // R6
  AST_IDLE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !head_wr && $past(!busy) |=> $stable(cur_desc) || busy); // R1
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $fell(busy)); // R8
endmodule

bind tx_gather_engine tx_gather_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/tx_gather_engine_tb.sv
module tx_gather_engine_tb;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic head_wr = 0, ctl_wr = 0, irq_clr = 0, mem_ack = 0, rdy_tog = 0, stall = 0, rmode = 0;
  logic [31:0] head_addr = 0, ctl_wdata = 0, mem_rdata = 0;
  logic [31:0] ctl_q, cur_desc, mem_addr, mem_wdata;
  logic irq_flag, busy, mem_req, mem_we, out_valid, out_last, out_ready;
  logic [7:0] out_data;
  assign out_ready = stall ? 1'b0 : (rmode ? rdy_tog : 1'b1);

  tx_gather_engine u_dut (.*);

  logic [31:0] mem [0:4095];
  int checks = 0, fails = 0;
  logic [7:0] exp_b[$], got_b[$], acc[$];
  bit exp_l[$], got_l[$];

  always @(negedge clk) begin
    rdy_tog <= ~rdy_tog;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
      else mem_rdata <= mem[mem_addr[13:2]];
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) if (out_valid && out_ready) begin
    got_b.push_back(out_data); got_l.push_back(out_last);
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL R9 watchdog: actual busy=%0d expected finish", busy);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic put_desc(input int i, input bit own, input int cnt, input bit last,
                          input int baddr, input int nxt);
    mem[i*4]   = {own, 23'd0, 8'hA5};
    mem[i*4+1] = {1'b0, last, 19'd0, 11'(cnt)};
    mem[i*4+2] = baddr;
    mem[i*4+3] = nxt;
    for (int w = 0; w < (cnt + 3) / 4; w++)
      mem[(baddr >> 2) + w] = {pat(baddr+4*w+3), pat(baddr+4*w+2), pat(baddr+4*w+1), pat(baddr+4*w)};
    for (int b = 0; b < cnt; b++) acc.push_back(pat(baddr + b));
    if (last) begin
      foreach (acc[k]) begin exp_b.push_back(acc[k]); exp_l.push_back(k == acc.size() - 1); end
      acc.delete();
    end
  endtask

  task automatic put_end(input int i);
    mem[i*4] = 32'h0000_0055; mem[i*4+1] = 0; mem[i*4+2] = 0; mem[i*4+3] = 0;
  endtask

  task automatic kick(input logic [31:0] v);
    @(negedge clk); ctl_wdata = v; ctl_wr = 1;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic wait_idle;
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic clear_streams;
    exp_b.delete(); exp_l.delete(); got_b.delete(); got_l.delete(); acc.delete();
  endtask

  task automatic cmp_stream(input string req);
    chk(got_b.size() == exp_b.size(), req, got_b.size(), exp_b.size());
    if (got_b.size() == exp_b.size())
      foreach (exp_b[k]) begin
        if (got_b[k] !== exp_b[k]) chk(0, req, got_b[k], exp_b[k]);
        if (got_l[k] !== exp_l[k]) chk(0, {req, " last"}, got_l[k], exp_l[k]);
      end
  endtask

  // [41:40] ready mode, [39:36] descriptors, [35:32] last mask, counts c0 [29:20], c1 [19:10], c2 [9:0]
  localparam logic [41:0] VEC [6] = '{
    {2'd0, 4'd1, 4'b0001, 2'b0, 10'd5,  10'd0,  10'd0},
    {2'd1, 4'd1, 4'b0001, 2'b0, 10'd64, 10'd0,  10'd0},
    {2'd0, 4'd3, 4'b0100, 2'b0, 10'd3,  10'd8,  10'd7},
    {2'd1, 4'd3, 4'b0111, 2'b0, 10'd4,  10'd1,  10'd9},
    {2'd0, 4'd2, 4'b0001, 2'b0, 10'd6,  10'd10, 10'd0},
    {2'd1, 4'd3, 4'b0010, 2'b0, 10'd0,  10'd2,  10'd3}
  };

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !irq_flag && !mem_req && !out_valid && cur_desc == 0 && ctl_q == 0,
        "R9 reset state", {busy, irq_flag, mem_req, out_valid}, 0);

    @(negedge clk); head_addr = 32'h40; head_wr = 1;
    @(negedge clk); head_wr = 0;
    chk(cur_desc == 32'h40, "R1 head load", cur_desc, 32'h40);
    @(negedge clk); head_addr = 0; head_wr = 1;
    @(negedge clk); head_wr = 0;

    kick(32'h8000_0000);
    chk(!busy && ctl_q == 32'h8000_0000, "R2 store without start", ctl_q, 32'h8000_0000);

    foreach (VEC[v]) begin
      int n, c[3];
      clear_streams();
      n = int'(VEC[v][39:36]); rmode = VEC[v][40];
      c[0] = int'(VEC[v][29:20]); c[1] = int'(VEC[v][19:10]); c[2] = int'(VEC[v][9:0]);
      for (int i = 0; i < n; i++) put_desc(i, 1, c[i], VEC[v][32+i], 32'h1000 + 32'h100*i, 16*(i+1));
      put_end(n);
      kick(32'hC000_0000);
      chk(busy, "R9 busy during walk", busy, 1);
      wait_idle();
      cmp_stream("R5 R4 gathered frame");
      for (int i = 0; i < n; i++)
        chk(mem[i*4] == 32'h0000_00A5, "R6 ownership returned", mem[i*4], 32'hA5);
      chk(mem[n*4] == 32'h55, "R3 unowned not written", mem[n*4], 32'h55);
      chk(irq_flag && ctl_q == 32'h4000_0000, "R8 completion", {irq_flag, ctl_q}, {1'b1, 32'h4000_0000});
      @(negedge clk); irq_clr = 1;
      @(negedge clk); irq_clr = 0;
      chk(!irq_flag, "R11 flag clear", irq_flag, 0);
    end
    rmode = 0;

    clear_streams();
    put_end(0);
    kick(32'hC000_0000); wait_idle();
    chk(got_b.size() == 0 && !irq_flag && ctl_q == 32'hC000_0000,
        "R3 R8 unowned head", ctl_q, 32'hC000_0000);

    clear_streams();
    put_desc(0, 1, 1500, 0, 32'h1000, 16);
    put_desc(1, 1, 1500, 1, 32'h2000, 32);
    put_end(2);
    kick(32'hC000_0000); wait_idle();
    chk(got_b.size() == 0, "R7 no bytes on overflow", got_b.size(), 0);
    chk(mem[0] == 32'h0000_00A5, "R7 first descriptor consumed", mem[0], 32'hA5);
    chk(mem[4] == 32'h8000_40A5, "R7 length error flagged", mem[4], 32'h8000_40A5);
    chk(!irq_flag && ctl_q == 32'hC000_0000, "R7 R8 no completion", ctl_q, 32'hC000_0000);

    clear_streams();
    put_desc(0, 1, 16, 1, 32'h1000, 16);
    put_end(1);
    stall = 1;
    kick(32'hC000_0000);
    while (!out_valid) @(negedge clk);
    begin
      logic [7:0] d0;
      d0 = out_data;
      @(negedge clk); @(negedge clk);
      chk(out_data == d0 && out_valid, "R10 held under stall", out_data, d0);
    end
    ctl_wdata = 32'h0000_1234; ctl_wr = 1; head_addr = 32'h300; head_wr = 1;
    @(negedge clk); ctl_wr = 0; head_wr = 0;
    chk(busy && ctl_q == 32'hC000_0000, "R9 kick ignored while busy", ctl_q, 32'hC000_0000);
    stall = 0;
    wait_idle();
    cmp_stream("R5 frame after stall");
    chk(ctl_q == 32'h4000_0000, "R9 R8 control after ignored write", ctl_q, 32'h4000_0000);
    @(negedge clk); head_addr = 32'h20; head_wr = 1;
    @(negedge clk); head_wr = 0;
    chk(cur_desc == 32'h20, "R1 head load after walk", cur_desc, 32'h20);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule